// File: doc/BRIEF.md
# Multi-Cycle Multiply Issue Controller

This block sits in an execute stage. It takes one multiply instruction (two 64-bit operands, a destination register number, a record flag and an overflow-enable flag), hands the operands to an internal multiplier whose latency is a parameter, and stalls the pipeline while the product is being formed. The multiplier only returns a product, a done strobe and an overflow flag. The controller holds the instruction's bookkeeping itself: the destination, both flags and a snapshot of the fixed-point status bits.

When the product comes back, the controller emits a one-cycle writeback bundle. The bundle carries the destination, the low 64 bits of the signed product, the updated status bits and, if requested, a 4-bit condition field built from the result. The updated status bits are fed straight back into the capture path. An instruction accepted in the writeback cycle therefore starts from them, and no hazard tracking is needed.

Top module: `mul_issue_ctrl`

## Requirements
- R1: After reset, `stall` and `wb_valid` are low and `wb_cr0_valid` is low.
- R2: An instruction is accepted in a cycle where `in_valid` is high and `stall` is low. With latency LAT, `stall` is high in the LAT-1 cycles after the accepting cycle and low in cycle LAT after it.
- R3: `wb_valid` is high for exactly one cycle, LAT cycles after acceptance. In that cycle `wb_result` is the low 64 bits of the signed product of `in_a` and `in_b`, and `wb_dest` is the destination given at acceptance.
- R4: Destination, record flag, overflow-enable flag and status bits are sampled at acceptance. Changes to them afterwards do not alter the writeback.
- R5: The status vector is {SO, OV, OV32, CA, CA32} at bits 4..0. With overflow-enable set, OV and OV32 in `wb_xer` equal the overflow flag, and SO becomes the old SO OR the overflow flag (SO is never cleared).
- R6: With overflow-enable clear, `wb_xer` equals the captured status bits. CA and CA32 always pass through unchanged.
- R7: With the record flag set, `wb_cr0_valid` is high and `wb_cr0` = {LT, GT, EQ, SO} at bits 3..0. LT and GT come from a signed compare of `wb_result` with zero, and SO is the updated SO bit. With the record flag clear, `wb_cr0_valid` and `wb_cr0` are 0.
- R8: Overflow is flagged when the full signed product does not fit in 64 signed bits.
- R9: `in_valid` pulses while `stall` is high are ignored: they start no operation and change no captured field.
- R10: An instruction accepted in the writeback cycle captures that cycle's updated status bits (`wb_xer`) instead of `xer_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Multiply instruction present |
| in_a | input | 64 | First operand (signed) |
| in_b | input | 64 | Second operand (signed) |
| in_dest | input | 5 | Destination register number |
| in_rc | input | 1 | Record flag: produce condition field |
| in_oe | input | 1 | Overflow-enable flag |
| xer_in | input | 5 | Current status bits {SO,OV,OV32,CA,CA32} |
| stall | output | 1 | Hold off the pipeline |
| wb_valid | output | 1 | Writeback bundle valid |
| wb_dest | output | 5 | Captured destination |
| wb_result | output | 64 | Low half of signed product |
| wb_xer | output | 5 | Updated status bits |
| wb_cr0_valid | output | 1 | Condition field present |
| wb_cr0 | output | 4 | {LT,GT,EQ,SO} |

## Verification
Counting from the cycle in which an instruction is accepted, `stall` is due high in cycles 1 through LAT-1. The whole writeback bundle, including status and condition bits, is due in cycle LAT, and in that cycle `stall` has already dropped. The bench drives inputs on falling edges and counts falling edges from the accepting edge. It checks the stall level on each one and reads the bundle on exactly the LAT-th. Every other operation is issued in that same writeback cycle, so the forwarded status bits are sampled on the same edge count.

// File: rtl/mic_pkg.sv
package mic_pkg;

   typedef struct packed {
      logic so;
      logic ov;
      logic ov32;
      logic ca;
      logic ca32;
   } stat_t;

   localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/mic_mul_unit.sv
module mic_mul_unit #(
   parameter int DATA_W = 64,
   parameter int LAT    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              done,
   output logic [DATA_W-1:0] product,
   output logic              ovf
);

   localparam int CNT_W  = $clog2(LAT + 1);
   localparam int FULL_W = 2 * DATA_W;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("mic_mul_unit: LAT must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("mic_mul_unit: DATA_W must be at least 2");
      end
   endgenerate

   logic signed [FULL_W-1:0] full;
   logic                     wide_ovf;
   logic [CNT_W-1:0]         cnt_q;
   logic [DATA_W-1:0]        prod_q;
   logic                     ovf_q;

   assign full     = $signed({{DATA_W{op_a[DATA_W-1]}}, op_a}) *
                     $signed({{DATA_W{op_b[DATA_W-1]}}, op_b});
   // upper half must be a pure sign extension of the lower half
   assign wide_ovf = (full[FULL_W-1:DATA_W] != {DATA_W{full[DATA_W-1]}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prod_q <= '0;
         ovf_q  <= 1'b0;
      end else if (start) begin
         cnt_q  <= CNT_W'(LAT);
         prod_q <= full[DATA_W-1:0];
         ovf_q  <= wide_ovf;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign done    = (cnt_q == CNT_W'(1));
   assign product = prod_q;
   assign ovf     = ovf_q;

   a_r3_no_early_done : assert property (@(posedge clk) disable iff (!rst_n)
      (start && LAT > 1) |=> !done);

   a_r3_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

endmodule

// File: rtl/mic_stat_upd.sv
module mic_stat_upd
   import mic_pkg::*;
(
   input  stat_t old_st,
   input  logic  oe,
   input  logic  ovf,
   output stat_t new_st
);

   always_comb begin
      new_st = old_st;
      if (oe) begin
         new_st.ov   = ovf;
         new_st.ov32 = ovf;
         new_st.so   = old_st.so | ovf;
      end
   end

endmodule

// File: rtl/mic_cr_gen.sv
module mic_cr_gen #(
   parameter int DATA_W = 64
) (
   input  logic              en,
   input  logic [DATA_W-1:0] value,
   input  logic              so,
   output logic [3:0]        field
);

   logic is_neg, is_zero;

   assign is_neg  = value[DATA_W-1];
   assign is_zero = (value == '0);

   always_comb begin
      if (en) field = {is_neg, !is_neg && !is_zero, is_zero, so};
      else    field = 4'b0000;
   end

endmodule

// File: rtl/mul_issue_ctrl.sv
module mul_issue_ctrl
   import mic_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int REG_W  = 5,
   parameter int LAT    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [REG_W-1:0]  in_dest,
   input  logic              in_rc,
   input  logic              in_oe,
   input  logic [4:0]        xer_in,
   output logic              stall,
   output logic              wb_valid,
   output logic [REG_W-1:0]  wb_dest,
   output logic [DATA_W-1:0] wb_result,
   output logic [4:0]        wb_xer,
   output logic              wb_cr0_valid,
   output logic [3:0]        wb_cr0
);

   generate
      if (STAT_W != 5) begin : g_bad_stat
         $error("mul_issue_ctrl: status vector must be 5 bits");
      end
      if (REG_W < 1) begin : g_bad_reg
         $error("mul_issue_ctrl: REG_W must be positive");
      end
   endgenerate

   logic              busy_q;
   logic              accept;
   logic              mul_done;
   logic              mul_ovf;
   logic [DATA_W-1:0] mul_prod;
   logic [REG_W-1:0]  dest_q;
   logic              rc_q;
   logic              oe_q;
   stat_t             st_q;
   stat_t             st_new;
   stat_t             st_src;

   assign stall  = busy_q & ~mul_done;
   assign accept = in_valid & ~stall;
   // forward freshly updated bits to an instruction taken in the writeback cycle
   assign st_src = mul_done ? st_new : stat_t'(xer_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dest_q <= '0;
         rc_q   <= 1'b0;
         oe_q   <= 1'b0;
         st_q   <= '0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            dest_q <= in_dest;
            rc_q   <= in_rc;
            oe_q   <= in_oe;
            st_q   <= st_src;
         end else if (mul_done) begin
            busy_q <= 1'b0;
         end
      end
   end

   mic_mul_unit #(.DATA_W(DATA_W), .LAT(LAT)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .op_a    (in_a),
      .op_b    (in_b),
      .done    (mul_done),
      .product (mul_prod),
      .ovf     (mul_ovf)
   );

   mic_stat_upd u_stat (
      .old_st (st_q),
      .oe     (oe_q),
      .ovf    (mul_ovf),
      .new_st (st_new)
   );

   mic_cr_gen #(.DATA_W(DATA_W)) u_cr (
      .en    (rc_q),
      .value (mul_prod),
      .so    (st_new.so),
      .field (wb_cr0)
   );

   assign wb_valid     = mul_done;
   assign wb_dest      = dest_q;
   assign wb_result    = mul_prod;
   assign wb_xer       = st_new;
   assign wb_cr0_valid = mul_done & rc_q;

   a_r2_stall_after_accept : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (stall || wb_valid));

   a_r9_hold_capture : assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(dest_q) && $stable(rc_q) && $stable(oe_q) && $stable(st_q)));

   a_r5_so_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && st_q.so) |-> wb_xer[4]);

   a_r6_carry_kept : assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_xer[1:0] == {st_q.ca, st_q.ca32}));

   a_r6_oe_clear_pass : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !oe_q) |-> (wb_xer == st_q));

   a_r7_no_rc_no_cr : assert property (@(posedge clk) disable iff (!rst_n)
      !rc_q |-> (wb_cr0 == 4'b0000 && !wb_cr0_valid));

   a_r1_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!stall && !wb_valid));

endmodule

// File: tb/mul_issue_ctrl_tb.sv
module mul_issue_ctrl_tb;

   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_a = '0, in_b = '0;
   logic [4:0]  in_dest = '0;
   logic        in_rc = 1'b0, in_oe = 1'b0;
   logic [4:0]  xer_in = '0;
   logic        stall, wb_valid, wb_cr0_valid;
   logic [4:0]  wb_dest, wb_xer;
   logic [63:0] wb_result;
   logic [3:0]  wb_cr0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mul_issue_ctrl #(.DATA_W(64), .REG_W(5), .LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_dest(in_dest), .in_rc(in_rc), .in_oe(in_oe), .xer_in(xer_in),
      .stall(stall), .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_result(wb_result),
      .wb_xer(wb_xer), .wb_cr0_valid(wb_cr0_valid), .wb_cr0(wb_cr0)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] opval(input int i);
      case (i % 8)
         0: return 64'd0;
         1: return 64'd1;
         2: return 64'hFFFF_FFFF_FFFF_FFFF;
         3: return 64'd7;
         4: return 64'h7FFF_FFFF_FFFF_FFFF;
         5: return 64'h8000_0000_0000_0000;
         6: return 64'h0000_0001_0000_0000;
         default: return 64'hFFFF_FFFF_FFFF_FFFD;
      endcase
   endfunction

   logic [4:0] prev_xer;
   logic       have_prev;

   task automatic run_sweep();
      have_prev = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 64; k++) begin
         logic [63:0]         a, b, res;
         logic signed [127:0] p;
         logic                ovf, oe, rc, fwd;
         logic [4:0]          eff, ex, dst;
         logic [3:0]          ecr;
         a   = opval(k / 8);
         b   = opval(k);
         oe  = k[1];
         rc  = k[2] ^ k[0];
         dst = 5'(k * 3 + 1);
         fwd = have_prev;
         eff = fwd ? prev_xer : 5'((k * 7) % 32);
         p   = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
         res = p[63:0];
         ovf = (p[127:64] != {64{res[63]}});
         ex  = eff;
         if (oe) begin
            ex[3] = ovf; ex[2] = ovf; ex[4] = eff[4] | ovf;
         end
         ecr = rc ? {res[63], !res[63] && res != 0, res == 0, ex[4]} : 4'b0;
         // drive the instruction (possibly in the writeback cycle of the previous one)
         in_valid = 1'b1; in_a = a; in_b = b; in_dest = dst;
         in_rc = rc; in_oe = oe; xer_in = fwd ? ~prev_xer : eff;
         for (int c = 1; c < LAT; c++) begin
            @(negedge clk);
            chk("R2 stall high", 128'(stall), 128'(1));
            chk("R3 no early wb", 128'(wb_valid), 128'(0));
            // garbage while stalled: must be ignored (R9, R4)
            in_valid = (c < LAT - 1);
            in_a = ~a; in_b = 64'd5; in_dest = ~dst; in_rc = ~rc; in_oe = ~oe;
            xer_in = ~eff;
         end
         @(negedge clk);
         chk("R2 stall low at wb", 128'(stall), 128'(0));
         chk("R3 wb valid", 128'(wb_valid), 128'(1));
         chk("R3 result", 128'(wb_result), 128'(res));
         chk("R4 R9 dest", 128'(wb_dest), 128'(dst));
         if (fwd) chk("R10 forwarded status", 128'(wb_xer), 128'(ex));
         else if (oe) chk("R5 R8 status", 128'(wb_xer), 128'(ex));
         else chk("R6 status pass", 128'(wb_xer), 128'(ex));
         chk("R7 cr0 valid", 128'(wb_cr0_valid), 128'(rc));
         chk("R7 cr0", 128'(wb_cr0), 128'(ecr));
         prev_xer = wb_xer;
         if (k[0]) begin
            have_prev = 1'b1;           // next one issues in this writeback cycle
         end else begin
            have_prev = 1'b0;
            in_valid = 1'b0;
            @(negedge clk);
            chk("R3 single pulse", 128'(wb_valid), 128'(0));
            chk("R1 idle stall", 128'(stall), 128'(0));
         end
      end
      in_valid = 1'b0;
      for (int c = 1; c <= LAT + 1; c++) @(negedge clk);
      chk("R9 no extra op", 128'(wb_valid), 128'(0));
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset stall", 128'(stall), 128'(0));
      chk("R1 reset wb", 128'(wb_valid), 128'(0));
      chk("R1 reset cr0", 128'(wb_cr0_valid), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      run_sweep();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule